// File: doc/BRIEF.md
# Always-On Pad Bank Controller

This block manages a bank of general-purpose pads that stay powered while the main power domain sleeps. It has a 32-bit register port with registered reads. For each pad it sets the pull resistor enable and direction, the output enable and the output value. Software can read back the synchronized input levels. A per-pad trigger detector latches level or edge events into a sticky status register, and the OR of that register forms a wake request.

One pad can carry a slow clock chosen from eight external clock inputs. The gate for that clock opens and closes only while the selected clock is low. A per-pad override bit hands a pad's settings to the main domain's control inputs, but only while that domain reports that it is powered.

Top module: `aon_pad_bank`

## Requirements
- R1: After reset, every pad has its pull enabled (`pad_pull_en_n`=0) as a pull-down (`pad_pull_up`=0) and its output disabled (`pad_oe_n`=0xFF, `pad_out`=0). Registers 0x1E8, 0x1F0, 0x1F4, 0x1F8 and 0x1FC read 0, and 0x1EC reads 0x000000FF.
- R2: Register 0x1E8 holds the pull direction in bits 15:8 (1 = pull-up) and the active-low pull enable in bits 7:0. Register 0x1EC holds the output values in bits 15:8 and the active-low output enables in bits 7:0. Bits with no field read 0 and ignore writes, including bit 1 of 0x1F0.
- R3: Bits 23:16 of 0x1EC return the pad input levels two clock edges after they change, and software writes to those bits have no effect.
- R4: When a pad is not overridden, it drives `pad_out`, `pad_oe_n`, `pad_pull_en_n` and `pad_pull_up` from its local register bits.
- R5: Bits 23:16 of 0x1F4 select override per pad. An overridden pad takes all four controls from the `main_*` inputs while `main_on`=1, and returns to its local bits while `main_on`=0.
- R6: Register 0x1F8 holds a 3-bit trigger code for pad i in bits 3i+2:3i. The codes are 0 off, 1 high level, 2 low level, 3 rising edge, 4 falling edge, 5 either edge, and 6 or 7 off. A match sets bit i of 0x1FC. For an edge, the bit is set three clock edges after the pad changes, and `wake_req` is the OR of the status bits.
- R7: Status bits are sticky and are cleared by writing 1. When a clear and a new event occur in the same cycle, the event wins, so a level that is still present keeps its bit set.
- R8: No event is detected on a pad while its effective output enable is 0, meaning the pad is driving.
- R9: Register 0x1F0 uses bit 0 as the clock-out enable and bits 4:2 as the source select. While the clock is gated on, pad 4 is driven (`pad_oe_n[4]`=0) with `slow_clk[select]`, and the other pads are unaffected.
- R10: The clock gate changes only after two consecutive low samples of the selected clock. After the enable is cleared, pad 4 returns to its local settings.
- R11: When the select changes while clock-out is enabled, the gate first closes at a low level, then switches source, then reopens at a low level of the new clock. Pad 4 never goes high while neither clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| main_on | input | 1 | Main domain powered |
| main_out | input | 8 | Main-domain output values |
| main_oe_n | input | 8 | Main-domain output enables, active low |
| main_pull_en_n | input | 8 | Main-domain pull enables, active low |
| main_pull_up | input | 8 | Main-domain pull direction |
| slow_clk | input | 8 | Candidate clocks for pad 4 |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe_n | output | 8 | Pad output enables, active low |
| pad_pull_en_n | output | 8 | Pull enables, active low |
| pad_pull_up | output | 8 | Pull direction, 1 = up |
| wake_req | output | 1 | OR of trigger status bits |

## Verification
A corrupted synchronizer or edge-history flop would show up as a status bit and `wake_req` set one cycle early or late, or set on the wrong edge. A stuck status bit would leave `wake_req` high after a write-1 clear. Both of these are visible within three cycles of the pad change. If the clock gate's state or selected source goes wrong, pad 4 follows the wrong clock or goes high while both candidate clocks are low. The bench checks pad 4 against the clocks at every cycle of the switch window, so such a fault is visible within one period of the slow clock.

// File: rtl/aon_pad_pkg.sv
package aon_pad_pkg;
  localparam logic [11:0] OFS_PADCFG = 12'h1E8;
  localparam logic [11:0] OFS_DATA   = 12'h1EC;
  localparam logic [11:0] OFS_CLKO   = 12'h1F0;
  localparam logic [11:0] OFS_OVR    = 12'h1F4;
  localparam logic [11:0] OFS_TMODE  = 12'h1F8;
  localparam logic [11:0] OFS_TSTAT  = 12'h1FC;

  typedef enum logic [2:0] {
    TRG_OFF  = 3'd0,
    TRG_HIGH = 3'd1,
    TRG_LOW  = 3'd2,
    TRG_RISE = 3'd3,
    TRG_FALL = 3'd4,
    TRG_BOTH = 3'd5
  } trig_mode_e;
endpackage

// File: rtl/aon_in_sync.sv
module aon_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv
);
  logic [W-1:0] s1_q, s2_q, s3_q;
  logic [W-1:0] s1_d, s2_d, s3_d;

  always_comb begin
    s1_d = din;
    s2_d = s1_q;
    s3_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
      s3_q <= s3_d;
    end
  end

  assign lvl = s2_q;
  assign prv = s3_q;
endmodule

// File: rtl/aon_trig_unit.sv
module aon_trig_unit
  import aon_pad_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic       prv,
  input  logic [2:0] mode,
  input  logic       armed,
  input  logic       clr,
  output logic       stat_o
);
  logic stat_q, stat_d, hit;
  trig_mode_e m;

  always_comb begin
    m = trig_mode_e'(mode);
    unique case (m)
      TRG_HIGH: hit = lvl;
      TRG_LOW:  hit = !lvl;
      TRG_RISE: hit = lvl && !prv;
      TRG_FALL: hit = !lvl && prv;
      TRG_BOTH: hit = lvl != prv;
      default:  hit = 1'b0;
    endcase
    hit = hit && armed;
    if (hit)      stat_d = 1'b1;
    else if (clr) stat_d = 1'b0;
    else          stat_d = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr) |=> stat_q); // R7
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mode == 3'd3 && lvl && !prv) |=> stat_q); // R6
  AST_DRIVEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !stat_q) |=> !stat_q); // R8
endmodule

// File: rtl/aon_clk_out.sv
module aon_clk_out #(
  parameter int NCLK  = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_req,
  input  logic [SEL_W-1:0] sel_req,
  input  logic [NCLK-1:0]  src,
  output logic             gate_o,
  output logic             clk_o
);
  logic             gate_q, gate_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             cs1_q, cs2_q, cs1_d, cs2_d;
  logic             raw, low_w, retarget;

  always_comb begin
    raw      = src[sel_q];
    low_w    = !cs1_q && !cs2_q;
    retarget = sel_req != sel_q;
    gate_d   = gate_q;
    sel_d    = sel_q;
    cs1_d    = raw;
    cs2_d    = cs1_q;
    if (!gate_q) begin
      if (en_req) begin
        if (retarget) begin
          sel_d = sel_req;
          cs1_d = 1'b1;
          cs2_d = 1'b1;
        end else if (low_w) begin
          gate_d = 1'b1;
        end
      end
    end else if ((!en_req || retarget) && low_w) begin
      gate_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      sel_q  <= '0;
      cs1_q  <= 1'b1;
      cs2_q  <= 1'b1;
    end else begin
      gate_q <= gate_d;
      sel_q  <= sel_d;
      cs1_q  <= cs1_d;
      cs2_q  <= cs2_d;
    end
  end

  assign gate_o = gate_q;
  assign clk_o  = gate_q & raw;

  AST_GATE_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q != $past(gate_q)) |-> ($past(cs1_q) == 1'b0 && $past(cs2_q) == 1'b0)); // R10
  AST_SEL_HELD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && $past(gate_q)) |-> (sel_q == $past(sel_q))); // R11
endmodule

// File: rtl/aon_pad_bank.sv
module aon_pad_bank
  import aon_pad_pkg::*;
#(
  parameter int NPAD    = 8,
  parameter int NCLK    = 8,
  parameter int CLK_PAD = 4,
  parameter int AW      = 12,
  parameter int DW      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_rvalid,
  input  logic            main_on,
  input  logic [NPAD-1:0] main_out,
  input  logic [NPAD-1:0] main_oe_n,
  input  logic [NPAD-1:0] main_pull_en_n,
  input  logic [NPAD-1:0] main_pull_up,
  input  logic [NCLK-1:0] slow_clk,
  input  logic [NPAD-1:0] pad_in,
  output logic [NPAD-1:0] pad_out,
  output logic [NPAD-1:0] pad_oe_n,
  output logic [NPAD-1:0] pad_pull_en_n,
  output logic [NPAD-1:0] pad_pull_up,
  output logic            wake_req
);
  localparam int SEL_W = (NCLK > 1) ? $clog2(NCLK) : 1;
  localparam int MW    = 3 * NPAD;

  // reset: asserted asynchronously, released through two flops
  logic rs1_q, rs2_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_ni = rs2_q;

  // register state
  logic [NPAD-1:0]  pen_n_q, pen_n_d, pup_q, pup_d;
  logic [NPAD-1:0]  out_q, out_d, oe_n_q, oe_n_d, ovr_q, ovr_d;
  logic             ckoe_q, ckoe_d;
  logic [SEL_W-1:0] cksel_q, cksel_d;
  logic [MW-1:0]    tmode_q, tmode_d;
  logic [DW-1:0]    rd_q, rd_d;
  logic             rv_q, rv_d;
  logic [NPAD-1:0]  clr_w, stat_w, lvl_w, prv_w;
  logic             wr_hit, rd_hit;

  assign wr_hit = bus_en && bus_we;
  assign rd_hit = bus_en && !bus_we;

  always_comb begin
    pen_n_d = pen_n_q;
    pup_d   = pup_q;
    out_d   = out_q;
    oe_n_d  = oe_n_q;
    ovr_d   = ovr_q;
    ckoe_d  = ckoe_q;
    cksel_d = cksel_q;
    tmode_d = tmode_q;
    clr_w   = '0;
    if (wr_hit) begin
      if (bus_addr == AW'(OFS_PADCFG)) begin
        pen_n_d = bus_wdata[0 +: NPAD];
        pup_d   = bus_wdata[8 +: NPAD];
      end
      if (bus_addr == AW'(OFS_DATA)) begin
        oe_n_d = bus_wdata[0 +: NPAD];
        out_d  = bus_wdata[8 +: NPAD];
      end
      if (bus_addr == AW'(OFS_CLKO)) begin
        ckoe_d  = bus_wdata[0];
        cksel_d = bus_wdata[2 +: SEL_W];
      end
      if (bus_addr == AW'(OFS_OVR))   ovr_d   = bus_wdata[16 +: NPAD];
      if (bus_addr == AW'(OFS_TMODE)) tmode_d = bus_wdata[0 +: MW];
      if (bus_addr == AW'(OFS_TSTAT)) clr_w   = bus_wdata[0 +: NPAD];
    end
  end

  always_comb begin
    rd_d = '0;
    rv_d = rd_hit;
    if (rd_hit) begin
      if (bus_addr == AW'(OFS_PADCFG)) begin
        rd_d[0 +: NPAD] = pen_n_q;
        rd_d[8 +: NPAD] = pup_q;
      end
      if (bus_addr == AW'(OFS_DATA)) begin
        rd_d[0 +: NPAD]  = oe_n_q;
        rd_d[8 +: NPAD]  = out_q;
        rd_d[16 +: NPAD] = lvl_w;
      end
      if (bus_addr == AW'(OFS_CLKO)) begin
        rd_d[0]         = ckoe_q;
        rd_d[2 +: SEL_W] = cksel_q;
      end
      if (bus_addr == AW'(OFS_OVR))   rd_d[16 +: NPAD] = ovr_q;
      if (bus_addr == AW'(OFS_TMODE)) rd_d[0 +: MW]    = tmode_q;
      if (bus_addr == AW'(OFS_TSTAT)) rd_d[0 +: NPAD]  = stat_w;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pen_n_q <= '0;
      pup_q   <= '0;
      out_q   <= '0;
      oe_n_q  <= '1;
      ovr_q   <= '0;
      ckoe_q  <= 1'b0;
      cksel_q <= '0;
      tmode_q <= '0;
      rd_q    <= '0;
      rv_q    <= 1'b0;
    end else begin
      pen_n_q <= pen_n_d;
      pup_q   <= pup_d;
      out_q   <= out_d;
      oe_n_q  <= oe_n_d;
      ovr_q   <= ovr_d;
      ckoe_q  <= ckoe_d;
      cksel_q <= cksel_d;
      tmode_q <= tmode_d;
      rd_q    <= rd_d;
      rv_q    <= rv_d;
    end
  end

  assign bus_rdata  = rd_q;
  assign bus_rvalid = rv_q;

  // input path
  aon_in_sync #(.W(NPAD)) u_sync (
    .clk(clk), .rst_n(rst_ni), .din(pad_in), .lvl(lvl_w), .prv(prv_w)
  );

  // clock-out gate
  logic gate_w, gclk_w;
  aon_clk_out #(.NCLK(NCLK), .SEL_W(SEL_W)) u_clko (
    .clk(clk), .rst_n(rst_ni), .en_req(ckoe_q), .sel_req(cksel_q),
    .src(slow_clk), .gate_o(gate_w), .clk_o(gclk_w)
  );

  // per-pad muxing and triggers
  for (genvar i = 0; i < NPAD; i++) begin : g_pin
    logic use_main, base_out, base_oe_n;
    assign use_main         = ovr_q[i] && main_on;
    assign base_out         = use_main ? main_out[i]  : out_q[i];
    assign base_oe_n        = use_main ? main_oe_n[i] : oe_n_q[i];
    assign pad_pull_en_n[i] = use_main ? main_pull_en_n[i] : pen_n_q[i];
    assign pad_pull_up[i]   = use_main ? main_pull_up[i]   : pup_q[i];
    if (i == CLK_PAD) begin : g_ck
      assign pad_out[i]  = gate_w ? gclk_w : base_out;
      assign pad_oe_n[i] = gate_w ? 1'b0   : base_oe_n;
    end else begin : g_pl
      assign pad_out[i]  = base_out;
      assign pad_oe_n[i] = base_oe_n;
    end
    aon_trig_unit u_trig (
      .clk(clk), .rst_n(rst_ni), .lvl(lvl_w[i]), .prv(prv_w[i]),
      .mode(tmode_q[3*i +: 3]), .armed(pad_oe_n[i]), .clr(clr_w[i]),
      .stat_o(stat_w[i])
    );
  end

  assign wake_req = |stat_w;

  AST_CLKPAD_DRIVEN: assert property (@(posedge clk) disable iff (!rst_ni)
    gate_w |-> !pad_oe_n[CLK_PAD]); // R9
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_rvalid |-> $past(bus_en && !bus_we)); // R2
endmodule

// File: tb/sim_aon_pad_bank.sv
module sim_aon_pad_bank;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_en, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic bus_rvalid, main_on, wake_req;
  logic [7:0] main_out, main_oe_n, main_pull_en_n, main_pull_up;
  logic [7:0] slow_clk, pad_in, pad_out, pad_oe_n, pad_pull_en_n, pad_pull_up;

  always #5 clk = ~clk;

  for (genvar k = 0; k < 8; k++) begin : g_sc
    initial begin
      slow_clk[k] = 1'b0;
      #2;
      forever #(40 + 10 * k) slow_clk[k] = ~slow_clk[k];
    end
  end

  aon_pad_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .main_on(main_on), .main_out(main_out),
    .main_oe_n(main_oe_n), .main_pull_en_n(main_pull_en_n),
    .main_pull_up(main_pull_up), .slow_clk(slow_clk), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe_n(pad_oe_n), .pad_pull_en_n(pad_pull_en_n),
    .pad_pull_up(pad_pull_up), .wake_req(wake_req)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare read data as it appears
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) chk("RD_EXTRA", 32'h1, 32'h0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        chk(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    item_t it;
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // pad 4 must never be high while both candidate clocks are low
  bit watch_sw = 0;
  int spur = 0;
  always @(negedge clk)
    if (watch_sw && pad_out[4] && !slow_clk[1] && !slow_clk[3]) spur++;

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int miss;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    main_on = 1'b0; main_out = '0; main_oe_n = '1; main_pull_en_n = '0;
    main_pull_up = '0; pad_in = '0;
    waitn(3);
    rst_n = 1'b1;
    waitn(4);

    // R1 reset state
    chk("R1 oe_n", {24'h0, pad_oe_n}, 32'hFF);
    chk("R1 out", {24'h0, pad_out}, 32'h0);
    chk("R1 pull_en_n", {24'h0, pad_pull_en_n}, 32'h0);
    chk("R1 pull_up", {24'h0, pad_pull_up}, 32'h0);
    chk("R1 wake", {31'h0, wake_req}, 32'h0);
    rd(12'h1E8, 32'h0, "R1 padcfg");
    rd(12'h1EC, 32'hFF, "R1 data");
    rd(12'h1F0, 32'h0, "R1 clko");
    rd(12'h1F4, 32'h0, "R1 ovr");
    rd(12'h1F8, 32'h0, "R1 tmode");
    rd(12'h1FC, 32'h0, "R1 tstat");

    // R2 layout and reserved bits, R4 local drive
    wr(12'h1E8, 32'hFFFF_A55A);
    rd(12'h1E8, 32'h0000_A55A, "R2 padcfg");
    chk("R4 pull_up", {24'h0, pad_pull_up}, 32'hA5);
    chk("R4 pull_en_n", {24'h0, pad_pull_en_n}, 32'h5A);
    wr(12'h1EC, 32'hFF00_3C0F);
    rd(12'h1EC, 32'h0000_3C0F, "R2 data");
    chk("R4 out", {24'h0, pad_out}, 32'h3C);
    chk("R4 oe_n", {24'h0, pad_oe_n}, 32'h0F);
    wr(12'h1EC, 32'h0000_00FF);
    wr(12'h1F0, 32'hFFFF_FFE2);
    rd(12'h1F0, 32'h0, "R2 clko reserved");

    // R3 input read-back
    pad_in = 8'h96;
    waitn(3);
    rd(12'h1EC, 32'h0096_00FF, "R3 input");
    wr(12'h1EC, 32'h00FF_00FF);
    rd(12'h1EC, 32'h0096_00FF, "R3 input ignores write");
    pad_in = 8'h00;
    waitn(4);

    // R5 override
    main_out = 8'hFF; main_oe_n = 8'h00; main_pull_en_n = 8'hFF; main_pull_up = 8'h00;
    main_on = 1'b1;
    wr(12'h1F4, 32'hFFF0_FFFF);
    rd(12'h1F4, 32'h00F0_0000, "R5 ovr");
    chk("R5 oe_n main", {24'h0, pad_oe_n}, 32'h0F);
    chk("R5 out main", {24'h0, pad_out}, 32'hF0);
    chk("R5 pull_en_n main", {24'h0, pad_pull_en_n}, 32'hFA);
    chk("R5 pull_up main", {24'h0, pad_pull_up}, 32'h05);
    main_on = 1'b0;
    #1;
    chk("R5 oe_n off", {24'h0, pad_oe_n}, 32'hFF);
    chk("R5 out off", {24'h0, pad_out}, 32'h00);
    wr(12'h1F4, 32'h0);

    // R6 rising on pad 0
    wr(12'h1F8, 32'h0000_0003);
    pad_in[0] = 1'b1;
    waitn(2);
    chk("R6 rise not early", {31'h0, wake_req}, 32'h0);
    waitn(1);
    chk("R6 rise wake", {31'h0, wake_req}, 32'h1);
    rd(12'h1FC, 32'h1, "R6 rise stat");
    wr(12'h1FC, 32'h1);
    chk("R7 w1c", {31'h0, wake_req}, 32'h0);

    // R6 falling on pad 1
    wr(12'h1F8, 32'h0000_0020);
    pad_in = 8'h02;
    waitn(4);
    rd(12'h1FC, 32'h0, "R6 fall ignores rise");
    pad_in = 8'h00;
    waitn(3);
    rd(12'h1FC, 32'h2, "R6 fall stat");
    wr(12'h1FC, 32'hFF);

    // R6/R7 high level on pad 2
    wr(12'h1F8, 32'h0000_0040);
    pad_in[2] = 1'b1;
    waitn(3);
    rd(12'h1FC, 32'h4, "R6 high stat");
    wr(12'h1FC, 32'h4);
    rd(12'h1FC, 32'h4, "R7 level wins clear");
    pad_in[2] = 1'b0;
    waitn(3);
    wr(12'h1FC, 32'h4);
    rd(12'h1FC, 32'h0, "R7 cleared");

    // R6 both edges on pad 3
    wr(12'h1F8, 32'h0000_0A00);
    pad_in[3] = 1'b1;
    waitn(3);
    rd(12'h1FC, 32'h8, "R6 both rise");
    wr(12'h1FC, 32'h8);
    pad_in[3] = 1'b0;
    waitn(3);
    rd(12'h1FC, 32'h8, "R6 both fall");
    wr(12'h1FC, 32'h8);

    // R6 low level on pad 5
    wr(12'h1F8, 32'h0001_0000);
    waitn(1);
    rd(12'h1FC, 32'h20, "R6 low stat");
    pad_in[5] = 1'b1;
    waitn(3);
    wr(12'h1FC, 32'hFF);
    rd(12'h1FC, 32'h0, "R6 low released");

    // R6 code 7 is off, on pad 6
    wr(12'h1F8, 32'h001C_0000);
    pad_in[6] = 1'b1;
    waitn(3);
    pad_in[6] = 1'b0;
    waitn(3);
    rd(12'h1FC, 32'h0, "R6 code7 off");
    pad_in = 8'h00;
    waitn(3);

    // R8 no detection while driving, pad 7
    wr(12'h1F8, 32'h0060_0000);
    wr(12'h1EC, 32'h0000_007F);
    pad_in[7] = 1'b1;
    waitn(4);
    rd(12'h1FC, 32'h0, "R8 driven quiet");
    pad_in[7] = 1'b0;
    waitn(3);
    wr(12'h1EC, 32'h0000_00FF);
    waitn(2);
    pad_in[7] = 1'b1;
    waitn(3);
    rd(12'h1FC, 32'h80, "R8 input detects");
    wr(12'h1FC, 32'hFF);
    wr(12'h1F8, 32'h0);
    pad_in = 8'h00;

    // R9 clock out on pad 4 from source 1
    wr(12'h1F0, 32'h0000_0005);
    rd(12'h1F0, 32'h5, "R9 clko readback");
    waitn(60);
    miss = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (pad_out[4] !== slow_clk[1] || pad_oe_n[4] !== 1'b0) miss++;
    end
    chk("R9 pad4 follows src1", miss, 0);
    chk("R9 others off", {24'h0, pad_oe_n & 8'hEF}, 32'hEF);

    // R11 switch source while enabled
    watch_sw = 1;
    wr(12'h1F0, 32'h0000_000D);
    waitn(200);
    watch_sw = 0;
    chk("R11 no spurious high", spur, 0);
    miss = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (pad_out[4] !== slow_clk[3] || pad_oe_n[4] !== 1'b0) miss++;
    end
    chk("R11 pad4 follows src3", miss, 0);

    // R10 disable returns pad 4 to local settings
    wr(12'h1F0, 32'h0);
    waitn(60);
    miss = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (pad_out[4] !== 1'b0 || pad_oe_n[4] !== 1'b1) miss++;
    end
    chk("R10 pad4 local again", miss, 0);

    waitn(4);
    chk("RD queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule